// File: doc/BRIEF.md
# Multi-lane SPI flash sequencer

This block is a SPI master for serial flash that moves data over one, two or four data lanes. The host loads an 8-bit transmit FIFO with a command byte followed by any address or write bytes, sets the number of bytes to read and pulses `start`. The sequencer pops the command first, and the command alone decides how the rest of the transaction runs. It sets whether an address and dummy clocks follow, how many lanes the read data uses, and which pins the master drives or releases in each phase.

A build parameter selects standard, dual or quad capability. A wider build still runs every single-lane command unchanged. An opcode that needs more lanes than the build has falls back to the generic single-lane path. Data read from the device is packed MSB first into an 8-bit receive FIFO. A read stops early, with chip select released, when that FIFO has no room for another byte.

Top module: `spi_flash_seq`

## Requirements
- R1: Both FIFOs are 8 bits wide and FIFO_DEPTH entries deep, where FIFO_DEPTH must be 16 or 256. After FIFO_DEPTH writes `tx_full` is high and further writes are dropped. Bytes leave each FIFO in the order they entered.
- R2: A `start` pulse while idle pops the head of the transmit FIFO as the command. A `start` while the transmit FIFO is empty is ignored: `cs_n` stays high and `busy` stays low.
- R3: The receive FIFO never overflows. When it holds FIFO_DEPTH bytes, the read ends with `cs_n` high even if the byte count is not used up.
- R4: SPI mode 0. `sck` is low whenever `cs_n` is high. Outputs change only on a falling `sck` edge or when `cs_n` falls. Inputs are sampled on the rising edge. One `sck` period lasts CLK_DIV system clocks, where CLK_DIV is even and at least 2.
- R5: The command byte and the address bytes are sent MSB first on `io_out[0]`. During those clocks `io_oe` is 4'b0001 and IO1 serves as the input.
- R6: Opcode 0x03 sends three address bytes and then reads `rd_len` bytes on `io_in[1]`, MSB first, with no dummy clocks.
- R7: Opcode 0x0B is like 0x03 but inserts 8 dummy clocks before the data. During the dummy clocks and the read data `io_oe` is 4'b0000.
- R8: In dual and quad builds, opcode 0x3B reads after 8 dummy clocks on two lanes. Each clock carries bits [7:6] first, on `io_in[1:0]`. IO2 and IO3 stay released.
- R9: In a quad build, opcode 0x6B reads after 8 dummy clocks on four lanes. Each clock carries nibble [7:4] first, on `io_in[3:0]`, so one byte takes two clocks.
- R10: Any other opcode, and 0x3B or 0x6B when the build lacks the lanes, runs a generic single-lane transfer. Every byte left in the transmit FIFO is sent on IO0, then `rd_len` bytes are read on IO1.
- R11: `cs_n` stays low without a break from the first command bit to the end of the transfer. `busy` is high while `cs_n` is low. `done` pulses for one cycle as `cs_n` rises.
- R12: With `rd_len` equal to 0 the transfer ends right after the address and dummy clocks, or after the write bytes, and no byte enters the receive FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (only while idle) |
| rd_len | input | LEN_W | Number of bytes to read, latched at start |
| tx_wr_en | input | 1 | Write strobe for the transmit FIFO |
| tx_wr_data | input | 8 | Byte to write into the transmit FIFO |
| tx_full | output | 1 | Transmit FIFO holds FIFO_DEPTH bytes |
| rx_rd_en | input | 1 | Pop the head of the receive FIFO |
| rx_rd_data | output | 8 | Head of the receive FIFO |
| rx_empty | output | 1 | Receive FIFO has no data |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle pulse when a transaction ends |
| sck | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Output values for IO3..IO0 |
| io_oe | output | 4 | Output enables for IO3..IO0 |
| io_in | input | 4 | Input values from IO3..IO0 |

## Verification
The bench builds two copies of the block with FIFO_DEPTH 16 and CLK_DIV 2: one quad build and one standard build. The shallow FIFO makes both the transmit-full limit and the early stop on a full receive FIFO reachable within a couple of hundred clocks. The fastest clock ratio puts an output change and an input sample on every system cycle. The bench sweeps every lane-selecting opcode over several byte counts, using a device model that returns arithmetic data patterns. The standard-build copy shows the dual and quad opcodes falling back to the generic single-lane path.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

   localparam int BUILD_STD  = 0;
   localparam int BUILD_DUAL = 1;
   localparam int BUILD_QUAD = 2;

   localparam logic [7:0] OP_READ      = 8'h03;
   localparam logic [7:0] OP_FAST_READ = 8'h0B;
   localparam logic [7:0] OP_DUAL_READ = 8'h3B;
   localparam logic [7:0] OP_QUAD_READ = 8'h6B;

   localparam int ADDR_BYTES = 3;

   typedef enum logic [1:0] {
      LN_1 = 2'd0,
      LN_2 = 2'd1,
      LN_4 = 2'd2
   } lane_e;

   typedef struct packed {
      logic  addr_phase;
      logic  dummy;
      lane_e lanes;
   } cmd_info_t;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_CMD   = 3'd1,
      S_ADDR  = 3'd2,
      S_WDATA = 3'd3,
      S_DUMMY = 3'd4,
      S_RDATA = 3'd5
   } seq_state_e;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = AW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count
);

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("spi_byte_fifo: DEPTH must be a power of two");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;
   logic             do_push;
   logic             do_pop;

   assign do_push = push && (count != CW'(DEPTH));
   assign do_pop  = pop  && (count != '0);
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH))
      else $error("a_r1_count_bound");

   a_r1_pop_moves: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && count != '0 && !push) |=> (count == $past(count) - 1'b1))
      else $error("a_r1_pop_moves");

endmodule

// File: rtl/spi_sck_tick.sv
module spi_sck_tick #(
   parameter int HALF = 1,
   localparam int TW = (HALF > 1) ? $clog2(HALF) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);

   if (HALF < 1) begin : g_bad_half
      $error("spi_sck_tick: HALF must be at least 1");
   end

   if (HALF == 1) begin : g_every_cycle
      assign tick = en;
   end else begin : g_counted
      logic [TW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        cnt <= '0;
         else if (!en)                      cnt <= '0;
         else if (cnt == TW'(HALF - 1))     cnt <= '0;
         else                               cnt <= cnt + 1'b1;
      end
      assign tick = en && (cnt == TW'(HALF - 1));

      a_r4_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick)
         else $error("a_r4_tick_spacing");
   end

endmodule

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_seq_pkg::*;
#(
   parameter int BUILD_MODE = BUILD_QUAD
) (
   input  logic [7:0] opcode,
   output cmd_info_t  info
);

   localparam cmd_info_t GENERIC = '{addr_phase: 1'b0, dummy: 1'b0, lanes: LN_1};

   if (BUILD_MODE == BUILD_QUAD) begin : g_quad
      always_comb begin
         case (opcode)
            OP_READ:      info = '{addr_phase: 1'b1, dummy: 1'b0, lanes: LN_1};
            OP_FAST_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_1};
            OP_DUAL_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_2};
            OP_QUAD_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_4};
            default:      info = GENERIC;
         endcase
      end
   end else if (BUILD_MODE == BUILD_DUAL) begin : g_dual
      always_comb begin
         case (opcode)
            OP_READ:      info = '{addr_phase: 1'b1, dummy: 1'b0, lanes: LN_1};
            OP_FAST_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_1};
            OP_DUAL_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_2};
            default:      info = GENERIC;
         endcase
      end
   end else begin : g_std
      always_comb begin
         case (opcode)
            OP_READ:      info = '{addr_phase: 1'b1, dummy: 1'b0, lanes: LN_1};
            OP_FAST_READ: info = '{addr_phase: 1'b1, dummy: 1'b1, lanes: LN_1};
            default:      info = GENERIC;
         endcase
      end
   end

   always_comb begin
      a_r10_lane_legal: assert (info.lanes != 2'd3)
         else $error("a_r10_lane_legal");
      a_r10_no_dummy_generic: assert (info.addr_phase || !info.dummy)
         else $error("a_r10_no_dummy_generic");
   end

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
   import spi_seq_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int BUILD_MODE = BUILD_QUAD,
   parameter int CLK_DIV    = 4,
   parameter int LEN_W      = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] rd_len,
   input  logic             tx_wr_en,
   input  logic [7:0]       tx_wr_data,
   output logic             tx_full,
   input  logic             rx_rd_en,
   output logic [7:0]       rx_rd_data,
   output logic             rx_empty,
   output logic             busy,
   output logic             done,
   output logic             sck,
   output logic             cs_n,
   output logic [3:0]       io_out,
   output logic [3:0]       io_oe,
   input  logic [3:0]       io_in
);

   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = $clog2(FIFO_DEPTH) + 1;
   localparam logic [CW-1:0] FULL_LVL = CW'(FIFO_DEPTH);
   localparam logic [CW-1:0] NEAR_LVL = CW'(FIFO_DEPTH - 1);

   if (FIFO_DEPTH != 16 && FIFO_DEPTH != 256) begin : g_bad_depth
      $error("spi_flash_seq: FIFO_DEPTH must be 16 or 256");
   end
   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("spi_flash_seq: CLK_DIV must be even and at least 2");
   end
   if (BUILD_MODE < BUILD_STD || BUILD_MODE > BUILD_QUAD) begin : g_bad_mode
      $error("spi_flash_seq: BUILD_MODE out of range");
   end
   if (LEN_W < 1) begin : g_bad_len
      $error("spi_flash_seq: LEN_W must be positive");
   end

   seq_state_e       state, state_nx;
   logic             sck_q, cs_q, done_q;
   logic [7:0]       sh_out, sh_in, sample_nxt;
   logic [2:0]       clk_idx;
   logic [1:0]       addr_left;
   logic [LEN_W-1:0] remain, len_q;
   cmd_info_t        info_q, dec_info;

   logic [7:0]    tx_head;
   logic [CW-1:0] tx_cnt, rx_cnt;
   logic          tx_empty;
   logic          tx_pop, rx_push;
   logic          tick, unit_last, unit_end, drive;
   seq_state_e    rd_entry;

   // FIFOs
   spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_wr_en),
      .din   (tx_wr_data),
      .pop   (tx_pop),
      .dout  (tx_head),
      .count (tx_cnt)
   );

   spi_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_push),
      .din   (sh_in),
      .pop   (rx_rd_en),
      .dout  (rx_rd_data),
      .count (rx_cnt)
   );

   assign tx_empty = (tx_cnt == '0);
   assign tx_full  = (tx_cnt == FULL_LVL);
   assign rx_empty = (rx_cnt == '0);

   // Half-period strobe and command decode
   spi_sck_tick #(.HALF(HALF)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (state != S_IDLE),
      .tick  (tick)
   );

   spi_cmd_decode #(.BUILD_MODE(BUILD_MODE)) u_decode (
      .opcode (tx_head),
      .info   (dec_info)
   );

   // Bit packing: how many clocks make a unit, and how input lanes fill a byte
   always_comb begin
      if (state == S_RDATA) begin
         case (info_q.lanes)
            LN_4:    unit_last = (clk_idx == 3'd1);
            LN_2:    unit_last = (clk_idx == 3'd3);
            default: unit_last = (clk_idx == 3'd7);
         endcase
      end else begin
         unit_last = (clk_idx == 3'd7);
      end
   end

   always_comb begin
      case (info_q.lanes)
         LN_4:    sample_nxt = {sh_in[3:0], io_in[3:0]};
         LN_2:    sample_nxt = {sh_in[5:0], io_in[1:0]};
         default: sample_nxt = {sh_in[6:0], io_in[1]};
      endcase
   end

   assign unit_end = (state != S_IDLE) && tick && sck_q && unit_last;

   // Phase sequencing
   always_comb begin
      rd_entry = ((len_q != '0) && (rx_cnt < FULL_LVL)) ? S_RDATA : S_IDLE;
      state_nx = state;
      case (state)
         S_IDLE:  if (start && !tx_empty) state_nx = S_CMD;
         S_CMD:   if (unit_end) state_nx = info_q.addr_phase ? S_ADDR :
                                           (!tx_empty ? S_WDATA : rd_entry);
         S_ADDR:  if (unit_end && addr_left == 2'd0)
                     state_nx = info_q.dummy ? S_DUMMY : rd_entry;
         S_WDATA: if (unit_end && tx_empty) state_nx = rd_entry;
         S_DUMMY: if (unit_end) state_nx = rd_entry;
         S_RDATA: if (unit_end && !((remain > LEN_W'(1)) && (rx_cnt < NEAR_LVL)))
                     state_nx = S_IDLE;
         default: state_nx = S_IDLE;
      endcase
   end

   always_comb begin
      tx_pop = 1'b0;
      if (state == S_IDLE)
         tx_pop = (state_nx == S_CMD);
      else if (unit_end && !tx_empty)
         tx_pop = (state == S_CMD) || (state == S_WDATA) ||
                  (state == S_ADDR && addr_left != 2'd0);
   end

   assign rx_push = unit_end && (state == S_RDATA);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         sck_q     <= 1'b0;
         cs_q      <= 1'b1;
         done_q    <= 1'b0;
         sh_out    <= '0;
         sh_in     <= '0;
         clk_idx   <= '0;
         addr_left <= '0;
         remain    <= '0;
         len_q     <= '0;
         info_q    <= '{addr_phase: 1'b0, dummy: 1'b0, lanes: LN_1};
      end else begin
         state  <= state_nx;
         done_q <= 1'b0;
         if (state == S_IDLE) begin
            if (state_nx == S_CMD) begin
               cs_q    <= 1'b0;
               sh_out  <= tx_head;
               info_q  <= dec_info;
               len_q   <= rd_len;
               clk_idx <= '0;
            end
         end else if (tick) begin
            sck_q <= !sck_q;
            if (!sck_q) begin
               if (state == S_RDATA) sh_in <= sample_nxt;
            end else if (!unit_last) begin
               clk_idx <= clk_idx + 1'b1;
               sh_out  <= {sh_out[6:0], 1'b0};
            end else begin
               clk_idx <= '0;
               sh_out  <= tx_pop ? tx_head : 8'h00;
               if (state == S_CMD && info_q.addr_phase)
                  addr_left <= 2'(ADDR_BYTES - 1);
               else if (state == S_ADDR && addr_left != 2'd0)
                  addr_left <= addr_left - 1'b1;
               if (state == S_RDATA)
                  remain <= remain - 1'b1;
               else if (state_nx == S_RDATA)
                  remain <= len_q;
               if (state_nx == S_IDLE) begin
                  cs_q   <= 1'b1;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   // Lane direction: only command, address and write bytes drive IO0
   assign drive  = (state == S_CMD) || (state == S_ADDR) || (state == S_WDATA);
   assign io_out = {3'b000, sh_out[7]};
   assign io_oe  = {3'b000, drive};
   assign sck    = sck_q;
   assign cs_n   = cs_q;
   assign busy   = (state != S_IDLE);
   assign done   = done_q;

   // Assertions
   a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !sck)
      else $error("a_r4_idle_low");

   a_r4_hold_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> ($stable(io_out) && $stable(io_oe)))
      else $error("a_r4_hold_on_rise");

   a_r4_sample_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sh_in) |-> $rose(sck))
      else $error("a_r4_sample_on_rise");

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      rx_push |-> (rx_cnt < FULL_LVL))
      else $error("a_r3_no_overflow");

   a_r5_cmd_driven: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_n) |-> (io_oe == 4'b0001 && !sck))
      else $error("a_r5_cmd_driven");

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cs_n && !busy) ##1 !done)
      else $error("a_r11_done_pulse");

   a_r11_busy_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_n |-> busy)
      else $error("a_r11_busy_frame");

   a_r2_no_empty_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && tx_empty) |=> (cs_n && !busy))
      else $error("a_r2_no_empty_start");

endmodule

// File: tb/tb_spi_flash_seq.sv
`timescale 1ns/1ps
module tb_spi_flash_seq;

   localparam int DEPTH = 16;
   localparam int DIV   = 2;
   localparam int LW    = 16;
   localparam int TCLK  = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(TCLK/2) clk = ~clk;

   logic          sel = 1'b0;
   logic          start = 1'b0, tx_wr_en = 1'b0, rx_rd_en = 1'b0;
   logic [7:0]    tx_wr_data = 8'h00;
   logic [LW-1:0] rd_len = '0;
   logic [3:0]    io_in;

   logic q_tx_full, q_rx_empty, q_busy, q_done, q_sck, q_cs_n;
   logic s_tx_full, s_rx_empty, s_busy, s_done, s_sck, s_cs_n;
   logic [7:0] q_rx_data, s_rx_data;
   logic [3:0] q_out, q_oe, s_out, s_oe;

   spi_flash_seq #(.FIFO_DEPTH(DEPTH), .BUILD_MODE(2), .CLK_DIV(DIV), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .start(start && !sel), .rd_len(rd_len),
      .tx_wr_en(tx_wr_en && !sel), .tx_wr_data(tx_wr_data), .tx_full(q_tx_full),
      .rx_rd_en(rx_rd_en && !sel), .rx_rd_data(q_rx_data), .rx_empty(q_rx_empty),
      .busy(q_busy), .done(q_done), .sck(q_sck), .cs_n(q_cs_n),
      .io_out(q_out), .io_oe(q_oe), .io_in(io_in));

   spi_flash_seq #(.FIFO_DEPTH(DEPTH), .BUILD_MODE(0), .CLK_DIV(DIV), .LEN_W(LW)) dut_std (
      .clk(clk), .rst_n(rst_n), .start(start && sel), .rd_len(rd_len),
      .tx_wr_en(tx_wr_en && sel), .tx_wr_data(tx_wr_data), .tx_full(s_tx_full),
      .rx_rd_en(rx_rd_en && sel), .rx_rd_data(s_rx_data), .rx_empty(s_rx_empty),
      .busy(s_busy), .done(s_done), .sck(s_sck), .cs_n(s_cs_n),
      .io_out(s_out), .io_oe(s_oe), .io_in(io_in));

   logic       m_sck, m_cs, m_busy, m_done, m_txf, m_rxe;
   logic [7:0] m_rxd;
   logic [3:0] m_out, m_oe;
   assign m_sck  = sel ? s_sck      : q_sck;
   assign m_cs   = sel ? s_cs_n     : q_cs_n;
   assign m_busy = sel ? s_busy     : q_busy;
   assign m_done = sel ? s_done     : q_done;
   assign m_txf  = sel ? s_tx_full  : q_tx_full;
   assign m_rxe  = sel ? s_rx_empty : q_rx_empty;
   assign m_rxd  = sel ? s_rx_data  : q_rx_data;
   assign m_out  = sel ? s_out      : q_out;
   assign m_oe   = sel ? s_oe       : q_oe;

   int n_chk = 0, n_fail = 0;
   int rc = 0, m_hdr = 0, m_drv = 0, m_w = 1;
   int oe_bad = 0, per_bad = 0, cs_rises = 0, done_cnt = 0;
   realtime last_rise = 0;
   logic [63:0] mosi = '0;
   logic [7:0]  txb [17];

   function automatic logic [7:0] pat(int k);
      return 8'((k * 29 + 90) % 256);
   endfunction

   function automatic logic [3:0] model_in(int rcv, int hdr, int w);
      logic [3:0] r;
      logic [7:0] b, ch;
      int d, cpb, j;
      r = 4'h0;
      if (rcv >= hdr) begin
         d   = rcv - hdr;
         cpb = 8 / w;
         j   = d % cpb;
         b   = pat(d / cpb);
         ch  = (b >> (8 - w * (j + 1))) & 8'((1 << w) - 1);
         if (w == 1) r[1] = ch[0];
         else        r    = ch[3:0];
      end
      return r;
   endfunction

   assign io_in = model_in(rc, m_hdr, m_w);

   // Device model: capture IO0, check directions and clock period at each rise
   always @(posedge m_sck) begin
      if (!m_cs) begin
         if (rc < 64) mosi[63 - rc] = m_out[0];
         if ((rc < m_drv) ? (m_oe != 4'b0001) : (m_oe != 4'b0000)) oe_bad++;
         if (rc > 0 && ($realtime - last_rise) != real'(DIV * TCLK)) per_bad++;
         last_rise = $realtime;
         rc++;
      end
   end
   always @(posedge m_cs) cs_rises++;
   always @(posedge clk) if (m_done) done_cnt++;

   task automatic chk(input bit ok, input string tag, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic push_bytes(input int nb);
      for (int i = 0; i < nb; i++) begin
         @(negedge clk); tx_wr_en = 1'b1; tx_wr_data = txb[i];
      end
      @(negedge clk); tx_wr_en = 1'b0;
   endtask

   task automatic run_txn(input bit use_std, input int nb, input int len, input int hdr,
                          input int drv, input int w, input int exp_edges,
                          input int exp_rx, input string tag);
      int nhb, bad;
      @(negedge clk);
      sel = use_std;
      rc = 0; m_hdr = hdr; m_drv = drv; m_w = w;
      oe_bad = 0; per_bad = 0; cs_rises = 0; done_cnt = 0; mosi = '0;
      push_bytes(nb);
      @(negedge clk); rd_len = LW'(len); start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (m_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(rc == exp_edges, tag, "sck rising edges", rc, exp_edges);
      chk(oe_bad == 0, tag, "output-enable mismatches (R5 R7)", oe_bad, 0);
      chk(per_bad == 0, tag, "sck period errors (R4)", per_bad, 0);
      chk(cs_rises == 1 && done_cnt == 1 && m_cs, tag, "cs_n releases and done pulses (R11)",
          cs_rises * 10 + done_cnt, 11);
      nhb = drv / 8;
      if (nhb > 8)  nhb = 8;
      if (nhb > nb) nhb = nb;
      bad = 0;
      for (int k = 0; k < nhb; k++) if (mosi[63 - 8*k -: 8] != txb[k]) bad++;
      chk(bad == 0, tag, "bytes on IO0 MSB first (R5)", bad, 0);
      bad = 0;
      for (int k = 0; k < exp_rx; k++) begin
         if (m_rxe || m_rxd != pat(k)) begin
            bad++;
            $display("  byte %0d: actual %0h expected %0h", k, m_rxd, pat(k));
         end
         rx_rd_en = 1'b1; @(negedge clk); rx_rd_en = 1'b0;
      end
      chk(bad == 0, tag, "received bytes", bad, 0);
      chk(m_rxe, tag, "receive FIFO drained to exact count", m_rxe, 1);
   endtask

   initial begin
      #(TCLK * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] ops [4];
      int nb;
      ops[0] = 8'h03; ops[1] = 8'h0B; ops[2] = 8'h3B; ops[3] = 8'h6B;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk(q_cs_n && !q_sck && q_oe == 4'b0000, "R4", "reset bus idle", {q_cs_n, q_sck}, 2);
      chk(!q_busy && !q_done && q_rx_empty && !q_tx_full, "R11", "reset status",
          {q_busy, q_done, q_rx_empty, q_tx_full}, 2);

      // R2: start with an empty transmit FIFO is ignored
      rc = 0; cs_rises = 0;
      @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
      repeat (20) @(negedge clk);
      chk(q_cs_n && !q_busy && rc == 0, "R2", "empty-FIFO start ignored", rc, 0);

      // Sweep the lane-selecting opcodes: R6 R7 R8 R9
      for (int op = 0; op < 4; op++) begin
         for (int n = 1; n <= 4; n++) begin
            int hdr, w;
            txb[0] = ops[op]; txb[1] = 8'(n * 16 + 1); txb[2] = 8'(op + 7); txb[3] = 8'hC3;
            hdr = (op == 0) ? 32 : 40;
            w   = (op == 2) ? 2 : ((op == 3) ? 4 : 1);
            run_txn(1'b0, 4, n, hdr, 32, w, hdr + (8 / w) * n, n,
                    (op == 0) ? "R6" : (op == 1) ? "R7" : (op == 2) ? "R8" : "R9");
         end
      end

      // R12: zero-length fast read ends after dummy clocks
      txb[0] = 8'h0B; txb[1] = 8'h00; txb[2] = 8'h10; txb[3] = 8'h20;
      run_txn(1'b0, 4, 0, 40, 32, 1, 40, 0, "R12");

      // R10: generic opcode with write bytes and a single-lane read
      txb[0] = 8'h9F; txb[1] = 8'hA1; txb[2] = 8'h5E;
      run_txn(1'b0, 3, 3, 24, 24, 1, 48, 3, "R10");

      // R10 R12: write-only generic transfer
      txb[0] = 8'h02; txb[1] = 8'h01; txb[2] = 8'h02; txb[3] = 8'h03;
      txb[4] = 8'hDE; txb[5] = 8'hAD;
      run_txn(1'b0, 6, 0, 48, 48, 1, 48, 0, "R12");

      // R3: read longer than the receive FIFO stops at FIFO_DEPTH bytes
      txb[0] = 8'h03; txb[1] = 8'h44; txb[2] = 8'h55; txb[3] = 8'h66;
      run_txn(1'b0, 4, 20, 32, 32, 1, 32 + 8 * DEPTH, DEPTH, "R3");

      // R1: transmit FIFO fills at DEPTH; the 17th write is dropped
      txb[0] = 8'h01;
      for (int i = 1; i < 17; i++) txb[i] = 8'(i * 11);
      @(negedge clk); sel = 1'b0;
      rc = 0; m_hdr = 1000; m_drv = 128; m_w = 1;
      oe_bad = 0; per_bad = 0; cs_rises = 0; done_cnt = 0; mosi = '0;
      push_bytes(17);
      chk(q_tx_full, "R1", "tx_full after FIFO_DEPTH writes", q_tx_full, 1);
      @(negedge clk); rd_len = '0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      while (q_busy) @(negedge clk);
      repeat (3) @(negedge clk);
      chk(rc == 8 * DEPTH, "R1", "only FIFO_DEPTH bytes sent", rc, 8 * DEPTH);
      nb = 0;
      for (int k = 0; k < 8; k++) if (mosi[63 - 8*k -: 8] != txb[k]) nb++;
      chk(nb == 0, "R1", "transmit order preserved", nb, 0);
      chk(oe_bad == 0 && !q_tx_full, "R5", "IO0 driven through write bytes", oe_bad, 0);

      // R10: standard build falls back to single lane for 0x6B and 0x3B
      txb[0] = 8'h6B; txb[1] = 8'h10; txb[2] = 8'h20; txb[3] = 8'h30;
      run_txn(1'b1, 4, 2, 32, 32, 1, 48, 2, "R10");
      txb[0] = 8'h3B;
      run_txn(1'b1, 4, 3, 32, 32, 1, 56, 3, "R10");
      // R6 on the standard build
      txb[0] = 8'h03;
      run_txn(1'b1, 4, 2, 32, 32, 1, 48, 2, "R6");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule